// File: doc/BRIEF.md
# Amplified ADC Conversion Sequencer

This controller schedules conversions on an amplified analog input. It runs on the converter clock and derives its own phase clock, which is the converter clock divided by eight. A software start request begins a conversion at once. The controller then lines up the sample-and-hold strobe with the selected synchronization source, counts the conversion cycles and marks the end of the conversion with a one-cycle pulse. The amplifier, the comparator and the successive-approximation datapath are outside this block. Each appears only as a single-bit strobe or flag.

The synchronization source is either the internal phase clock or an external trigger event from a PWM controller. On the internal source, the length of a software-started conversion depends on the phase clock level when the request is taken. If the amplifier reports a change while the input is being sampled, the conversion is abandoned. It restarts once the amplifier has settled. A separate monitor flags external triggers that arrive closer together than the converter can follow.

Top module: `amp_conv_sequencer`

## Requirements
- R1: After reset the phase clock `sync_clk` is low for 4 cycles, then high for 4 cycles, and repeats with a period of 8 converter clocks.
- R2: A start request taken when `busy` is low sets `busy` on the next cycle. On the internal source, with `sync_clk` low at the request edge, `done` pulses 13 cycles after that edge.
- R3: On the internal source, with `sync_clk` high at the request edge, `done` pulses 14 cycles after the request edge. One alignment cycle comes before the count.
- R4: `sh_strobe` is high for exactly the first count cycle of each conversion attempt. That is the cycle after the request edge at low phase, and the cycle after that at high phase.
- R5: `busy` (the start bit) stays high until the conversion ends. `done` is a single-cycle pulse, and in single mode `busy` is low in the same cycle that `done` is high.
- R6: A request made while `busy` is high, for any channel, is ignored. `cur_chan` keeps the latched channel and the completion time does not move.
- R7: If `amp_chg` is high at an edge in count cycle 0 or 1, the attempt is dropped. The count restarts from 0 at the first edge where `amp_chg` is low. When `amp_chg` is held from sample cycle s (1 or 2 after the request) for k cycles, `done` comes s+k+13 cycles after the request.
- R8: `amp_chg` in count cycle 2 or later has no effect on the completion time.
- R9: Source code `src_sel`=2'b01 selects the external trigger. The conversion waits for the first `ext_trig` edge after the request and ends 13 cycles after it. All other codes select the internal phase clock, where `ext_trig` has no effect.
- R10: With `free_run` high at the end of a conversion, `busy` stays high and the next internal-source conversion follows immediately with 13 cycles and no alignment. The last conversion ends with `busy` low.
- R11: `trig_err` pulses in the cycle after an `ext_trig` edge that comes 4 or fewer edges after the previous trigger. Larger spacing gives no pulse.
- R12: While `rst` is high, `busy`, `done`, `sh_strobe`, `trig_err` and `sync_clk` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Software start request |
| req_chan | input | CH_W | Channel named by the request |
| src_sel | input | 2 | Synchronization source code (2'b01 external) |
| free_run | input | 1 | Chain conversions back to back |
| amp_chg | input | 1 | Amplifier output changing flag |
| ext_trig | input | 1 | External PWM trigger event |
| sync_clk | output | 1 | Divided phase clock |
| busy | output | 1 | Start bit / conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| sh_strobe | output | 1 | Sample-and-hold strobe |
| cur_chan | output | CH_W | Channel of the current or last conversion |
| trig_err | output | 1 | Trigger spacing violation pulse |

## Verification
Each completion time is measured in converter cycles from the request edge. The expected value is 13 or 14 on the internal source (chosen by the request phase, which the bench sweeps over all eight values), j+13 for a trigger j cycles later, and s+k+13 after a sample-phase disturbance. `busy` is due one cycle after the request, and `trig_err` one cycle after the offending trigger. Stimuli are driven and outputs sampled on falling edges, and the bench counts falling edges from the request, so a rising-edge event at offset n is read at falling edge n+1.

// File: rtl/amp_seq_pkg.sv
`timescale 1ns/1ps
package amp_seq_pkg;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ALIGN  = 3'd1,
        ST_ARM    = 3'd2,
        ST_CONV   = 3'd3,
        ST_SETTLE = 3'd4
    } seq_state_e;

    // Source select code for the external trigger; every other code
    // selects the internal divided phase clock.
    localparam logic [1:0] SRC_EXT_CODE = 2'b01;

    // Status bundle leaving the sequencer core
    typedef struct packed {
        logic busy;
        logic done;
        logic strobe;
    } seq_status_t;

    function automatic logic src_is_external(input logic [1:0] sel);
        return sel == SRC_EXT_CODE;
    endfunction

endpackage

// File: rtl/amp_seq_divider.sv
`timescale 1ns/1ps
module amp_seq_divider #(
    parameter int DIV_LOG2 = 3
) (
    input  logic clk,
    input  logic rst,
    output logic sync_hi
);
    logic [DIV_LOG2-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_q + 1'b1;
    end

    // Top bit is the divided phase clock: low for the first half period
    assign sync_hi = div_q[DIV_LOG2-1];
endmodule

// File: rtl/amp_seq_trig_mon.sv
`timescale 1ns/1ps
module amp_seq_trig_mon #(
    parameter int MIN_GAP = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic err
);
    localparam int GAP_W = $clog2(MIN_GAP + 1);
    localparam logic [GAP_W-1:0] GAP_SAT = GAP_W'(MIN_GAP);

    // Edges elapsed since the last trigger, not counting the trigger edge;
    // saturates so that the very first trigger is never flagged.
    logic [GAP_W-1:0] since_q;
    logic             err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= GAP_SAT;
            err_q   <= 1'b0;
        end else begin
            err_q <= trig && (since_q < GAP_SAT);
            if (trig)
                since_q <= '0;
            else if (since_q < GAP_SAT)
                since_q <= since_q + 1'b1;
        end
    end

    assign err = err_q;
endmodule

// File: rtl/amp_seq_fsm.sv
`timescale 1ns/1ps
module amp_seq_fsm
    import amp_seq_pkg::*;
#(
    parameter int CH_W          = 4,
    parameter int CONV_CYCLES   = 13,
    parameter int SAMPLE_CYCLES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req,
    input  logic [CH_W-1:0] chan,
    input  logic [1:0]      src_sel,
    input  logic            free_run,
    input  logic            amp_chg,
    input  logic            trig,
    input  logic            sync_hi,
    output seq_status_t     status,
    output logic [CH_W-1:0] cur_chan
);
    localparam int CNT_W = $clog2(CONV_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONV_CYCLES - 1);
    localparam logic [CNT_W-1:0] CNT_SAMP = CNT_W'(SAMPLE_CYCLES);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CH_W-1:0]  chan_q;
    logic             ext_q;
    logic             done_q;
    logic             in_sample;

    assign in_sample = (cnt_q < CNT_SAMP);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            chan_q  <= '0;
            ext_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req) begin
                        chan_q <= chan;
                        ext_q  <= src_is_external(src_sel);
                        cnt_q  <= '0;
                        if (src_is_external(src_sel))
                            state_q <= ST_ARM;
                        else if (sync_hi)
                            state_q <= ST_ALIGN;
                        else
                            state_q <= ST_CONV;
                    end
                end
                ST_ALIGN: begin
                    state_q <= ST_CONV;
                    cnt_q   <= '0;
                end
                ST_ARM: begin
                    if (trig) begin
                        state_q <= ST_CONV;
                        cnt_q   <= '0;
                    end
                end
                ST_CONV: begin
                    if (amp_chg && in_sample) begin
                        state_q <= ST_SETTLE;
                    end else if (cnt_q == CNT_LAST) begin
                        done_q <= 1'b1;
                        cnt_q  <= '0;
                        if (!free_run)
                            state_q <= ST_IDLE;
                        else if (ext_q)
                            state_q <= ST_ARM;
                        else
                            state_q <= ST_CONV;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_SETTLE: begin
                    if (!amp_chg) begin
                        state_q <= ST_CONV;
                        cnt_q   <= '0;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        status.busy   = (state_q != ST_IDLE);
        status.done   = done_q;
        status.strobe = (state_q == ST_CONV) && (cnt_q == '0);
    end

    assign cur_chan = chan_q;
endmodule

// File: rtl/amp_conv_sequencer.sv
`timescale 1ns/1ps
module amp_conv_sequencer
    import amp_seq_pkg::*;
#(
    parameter int CH_W          = 4,
    parameter int DIV_LOG2      = 3,
    parameter int CONV_CYCLES   = 13,
    parameter int SAMPLE_CYCLES = 2,
    parameter int TRIG_MIN_GAP  = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_req,
    input  logic [CH_W-1:0] req_chan,
    input  logic [1:0]      src_sel,
    input  logic            free_run,
    input  logic            amp_chg,
    input  logic            ext_trig,
    output logic            sync_clk,
    output logic            busy,
    output logic            done,
    output logic            sh_strobe,
    output logic [CH_W-1:0] cur_chan,
    output logic            trig_err
);
    seq_status_t stat;
    logic        sync_hi;

    amp_seq_divider #(.DIV_LOG2(DIV_LOG2)) u_div (
        .clk     (clk),
        .rst     (rst),
        .sync_hi (sync_hi)
    );

    amp_seq_trig_mon #(.MIN_GAP(TRIG_MIN_GAP)) u_mon (
        .clk  (clk),
        .rst  (rst),
        .trig (ext_trig),
        .err  (trig_err)
    );

    amp_seq_fsm #(
        .CH_W          (CH_W),
        .CONV_CYCLES   (CONV_CYCLES),
        .SAMPLE_CYCLES (SAMPLE_CYCLES)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .req      (start_req),
        .chan     (req_chan),
        .src_sel  (src_sel),
        .free_run (free_run),
        .amp_chg  (amp_chg),
        .trig     (ext_trig),
        .sync_hi  (sync_hi),
        .status   (stat),
        .cur_chan (cur_chan)
    );

    assign sync_clk  = sync_hi;
    assign busy      = stat.busy;
    assign done      = stat.done;
    assign sh_strobe = stat.strobe;
endmodule

// File: rtl/amp_seq_chk.sv
`timescale 1ns/1ps
module amp_seq_chk #(
    parameter int CH_W = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            start_req,
    input logic            ext_trig,
    input logic            sync_clk,
    input logic            busy,
    input logic            done,
    input logic            sh_strobe,
    input logic [CH_W-1:0] cur_chan,
    input logic            trig_err
);
    // R1
    sync_half_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_clk) |=> sync_clk);

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (start_req && !busy) |=> busy);

    // R4
    strobe_busy_chk: assert property (@(posedge clk) disable iff (rst)
        sh_strobe |-> busy);

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    chan_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cur_chan));

    // R11
    trig_err_src_chk: assert property (@(posedge clk) disable iff (rst)
        trig_err |-> $past(ext_trig));
endmodule

bind amp_conv_sequencer amp_seq_chk #(.CH_W(CH_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_req (start_req),
    .ext_trig  (ext_trig),
    .sync_clk  (sync_clk),
    .busy      (busy),
    .done      (done),
    .sh_strobe (sh_strobe),
    .cur_chan  (cur_chan),
    .trig_err  (trig_err)
);

// File: tb/tb_amp_conv_sequencer.sv
`timescale 1ns/1ps
module tb_amp_conv_sequencer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_req = 1'b0;
    logic [3:0] req_chan = '0;
    logic [1:0] src_sel = '0;
    logic       free_run = 1'b0;
    logic       amp_chg = 1'b0;
    logic       ext_trig = 1'b0;
    logic       sync_clk, busy, done, sh_strobe, trig_err;
    logic [3:0] cur_chan;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [2:0] ph;

    always #2 clk = ~clk;

    // Arithmetic phase model: cycles since reset release, modulo 8
    always @(posedge clk) begin
        if (rst) ph <= '0;
        else     ph <= ph + 3'd1;
    end

    amp_conv_sequencer dut (
        .clk(clk), .rst(rst), .start_req(start_req), .req_chan(req_chan),
        .src_sel(src_sel), .free_run(free_run), .amp_chg(amp_chg),
        .ext_trig(ext_trig), .sync_clk(sync_clk), .busy(busy), .done(done),
        .sh_strobe(sh_strobe), .cur_chan(cur_chan), .trig_err(trig_err)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic wait_phase(input int p);
        while (ph != 3'(p)) @(negedge clk);
    endtask

    // Issues a request at the current falling edge and counts falling edges
    // until done. Side stimuli are keyed to falling edge n after the request.
    task automatic run_req(input logic [3:0] ch, input logic [1:0] src,
                           input int amp_s, input int amp_k, input int trig_j,
                           input int blk_n, output int len, output int strobe_at,
                           output int busy1, output int busy_end, output int chan_end);
        int n;
        start_req = 1'b1; req_chan = ch; src_sel = src;
        @(negedge clk);
        n = 1; strobe_at = -1; busy1 = busy;
        while (n < 200) begin
            if (done) break;
            if (sh_strobe && strobe_at < 0) strobe_at = n;
            amp_chg   = (n >= amp_s) && (n < amp_s + amp_k);
            ext_trig  = (n == trig_j);
            start_req = (n == blk_n);
            req_chan  = (n == blk_n) ? ~ch : ch;
            @(negedge clk);
            n++;
        end
        amp_chg = 0; ext_trig = 0; start_req = 0;
        len = n - 1; busy_end = busy; chan_end = cur_chan;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

    initial begin
        int len, sa, b1, be, ce;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(!busy && !done && !sh_strobe && !trig_err && !sync_clk, "R12",
            {busy, done, sh_strobe, trig_err, sync_clk}, 0);
        rst = 1'b0;
        // R1 divider pattern
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            chk(sync_clk == ph[2], "R1", sync_clk, ph[2]);
        end
        // R2/R3/R4/R5/R6: sweep every request phase on the internal source
        for (int p = 0; p < 8; p++) begin
            wait_phase(p);
            run_req(4'(p + 1), 2'b00, 99, 0, 0, 5, len, sa, b1, be, ce);
            chk(b1 == 1, "R2 busy after request", b1, 1);
            if (p >= 4) chk(len == 14, "R3 length", len, 14);
            else        chk(len == 13, "R2 length", len, 13);
            chk(sa == ((p >= 4) ? 2 : 1), "R4 strobe", sa, (p >= 4) ? 2 : 1);
            chk(be == 0, "R5 busy at done", be, 0);
            chk(ce == p + 1, "R6 channel kept", ce, p + 1);
            @(negedge clk);
            chk(!done, "R5 done width", done, 0);
        end
        // R7 sample-phase disturbance
        for (int s = 1; s <= 2; s++) begin
            for (int k = 1; k <= 3; k++) begin
                wait_phase(0);
                run_req(4'h3, 2'b00, s, k, 0, 0, len, sa, b1, be, ce);
                chk(len == s + k + 13, "R7 restart", len, s + k + 13);
            end
        end
        // R8 disturbance outside the sample window
        for (int s = 3; s <= 8; s += 5) begin
            wait_phase(0);
            run_req(4'h4, 2'b00, s, 2, 0, 0, len, sa, b1, be, ce);
            chk(len == 13, "R8 late change", len, 13);
        end
        // R9 external source: trigger j cycles after the request
        for (int j = 1; j <= 4; j++) begin
            repeat (6) @(negedge clk);
            run_req(4'h5, 2'b01, 99, 0, j, 0, len, sa, b1, be, ce);
            chk(len == j + 13, "R9 external", len, j + 13);
        end
        // R9 other codes are internal; triggers ignored
        for (int c = 2; c <= 3; c++) begin
            repeat (6) @(negedge clk);
            wait_phase(1);
            run_req(4'h6, 2'(c), 99, 0, 3, 0, len, sa, b1, be, ce);
            chk(len == 13, "R9 internal code", len, 13);
        end
        // R10 free running: second conversion 13 cycles, no alignment
        wait_phase(5);
        free_run = 1'b1;
        run_req(4'h7, 2'b00, 99, 0, 0, 0, len, sa, b1, be, ce);
        chk(len == 14, "R10 first length", len, 14);
        chk(be == 1, "R10 busy held", be, 1);
        free_run = 1'b0;
        len = 0;
        while (len < 100) begin
            @(negedge clk);
            len++;
            if (done) break;
        end
        chk(len == 13, "R10 chained length", len, 13);
        chk(busy == 0, "R10 busy after last", busy, 0);
        // R11 trigger spacing
        for (int g = 1; g <= 7; g++) begin
            repeat (8) @(negedge clk);
            ext_trig = 1'b1;
            @(negedge clk);
            chk(!trig_err, "R11 isolated trigger", trig_err, 0);
            for (int i = 1; i < g; i++) begin
                ext_trig = 1'b0;
                @(negedge clk);
            end
            ext_trig = 1'b1;
            @(negedge clk);
            ext_trig = 1'b0;
            chk(trig_err == (g <= 4), "R11 spacing", trig_err, (g <= 4));
        end
        finish_run();
    end
endmodule